// File: doc/BRIEF.md
# Converter Serial Output Sequencer

This block is the digital output side of a converter that drives its own serial clock. It loops through three phases: a conversion, during which the serial clock, the serial data line and the busy flag all sit high; a short sleep, during which all three drop low; and a data phase. In the data phase the block generates the serial clock itself and shifts out a result word, most significant bit first. When the last bit has been presented, the block returns to conversion on its own.

An active-low select input can cut the data phase short. A low-to-high transition on it, once at least one clock rising edge has gone out, ends the transfer and starts a new conversion on the next cycle.

The conversion length is a base cycle count multiplied by one plus an oversampling code. Normally that code is the programmed value. After an early abort, the code instead follows the number of rising edges already sent. The data line's output enable drops whenever the select is high during the data phase.

Top module: `cnv_out_seq`

## Requirements
- R1: While converting, `busy_o`, `sck_o` and `sdo_o` are all 1. A conversion lasts `CONV_BASE*(k+1)` cycles for oversampling code k. The first conversion after reset uses k = 0.
- R2: When a conversion ends, `busy_o`, `sck_o` and `sdo_o` are all 0 for exactly `SLEEP_CYC` cycles. The word on `result_i` in the last conversion cycle is captured for output.
- R3: In the data phase, `sck_o` is 0 for `HALF_CYC` cycles and then toggles every `HALF_CYC` cycles, giving 32 rising edges. `sdo_o` carries captured bit 31 first and moves one bit lower at each falling edge of `sck_o`, so bit 31-n is valid across rising edge n+1.
- R4: After the 32nd rising edge, `sck_o` stays 1 for `HALF_CYC` cycles. A conversion then starts with k equal to `osr_i`.
- R5: A rise of `cs_ni` (sampled 0 then 1 on consecutive clocks) during the data phase, after at least one rising edge of `sck_o`, starts a conversion on the next cycle.
- R6: For an abort with n rising edges seen, k is n when n < 5 and `osr_i` when n >= 5.
- R7: Conversions that follow a normal, unaborted data phase use `osr_i` again.
- R8: A rise of `cs_ni` during conversion, during sleep, or in the data phase before the first rising edge has no effect on the sequence.
- R9: `sdo_oe_o` is 0 when `cs_ni` is 1 during the data phase, and 1 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low select; a rise during data output aborts the transfer |
| osr_i | input | OSR_W | Programmed oversampling code |
| result_i | input | WORD_W | Result word captured at the end of conversion |
| sck_o | output | 1 | Generated serial clock |
| sdo_o | output | 1 | Serial data / end-of-conversion indicator |
| sdo_oe_o | output | 1 | Output enable for the serial data line |
| busy_o | output | 1 | High while converting |

## Verification
A wrong phase or timer value shows at once as a mismatch on `busy_o`, `sck_o` or `sdo_o`. A corrupted bit pointer shows on `sdo_o` within one half-period of the serial clock. A wrong oversampling choice after an abort shows only at the end of the following conversion, when the busy flag falls early or late, which can be up to `CONV_BASE*2^OSR_W` cycles later. Comparing every output on every cycle against a reference model therefore covers both the immediate errors and the late ones.

// File: rtl/cnv_out_pkg.sv
package cnv_out_pkg;
  typedef enum logic [1:0] {ST_CONV, ST_SLEEP, ST_DATA} seq_state_e;
endpackage

// File: rtl/cnv_out_timer.sv
module cnv_out_timer #(
  parameter int TW      = 8,
  parameter int RST_VAL = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= TW'(RST_VAL);
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - TW'(1);
  end

  assign done_o = (cnt_q == '0);

  // R1
  tmr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !done_o |=> cnt_q == $past(cnt_q) - TW'(1));
endmodule

// File: rtl/cnv_out_sckgen.sv
module cnv_out_sckgen #(
  parameter int HALF_CYC = 2,
  parameter int PH_W     = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  output logic [PH_W-1:0] ph_o,
  output logic            half_end_o
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [HW-1:0]   hc_q;
  logic [PH_W-1:0] ph_q;

  assign half_end_o = (hc_q == HW'(HALF_CYC - 1));
  assign ph_o       = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q <= '0;
      ph_q <= '0;
    end else if (clr_i) begin
      hc_q <= '0;
      ph_q <= '0;
    end else if (en_i) begin
      if (half_end_o) begin
        hc_q <= '0;
        ph_q <= ph_q + PH_W'(1);
      end else begin
        hc_q <= hc_q + HW'(1);
      end
    end
  end

  // R3
  half_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && !half_end_o |=> $stable(ph_o));
endmodule

// File: rtl/cnv_out_osr.sv
module cnv_out_osr #(
  parameter int OSR_W     = 4,
  parameter int PH_W      = 6,
  parameter int TW        = 8,
  parameter int CONV_BASE = 8,
  parameter int ABORT_MIN = 5
) (
  input  logic [OSR_W-1:0] osr_prog_i,
  input  logic [PH_W:0]    rises_i,
  input  logic             abort_i,
  output logic [TW-1:0]    len_m1_o
);
  logic [OSR_W-1:0] osr_eff;

  always_comb begin
    osr_eff = osr_prog_i;
    if (abort_i && (int'(rises_i) < ABORT_MIN)) osr_eff = OSR_W'(rises_i);
  end

  assign len_m1_o = TW'(CONV_BASE * (int'(osr_eff) + 1) - 1);

  initial begin
    // R6
    osr_width_chk: assert (OSR_W >= $clog2(ABORT_MIN));
  end
endmodule

// File: rtl/cnv_out_seq.sv
module cnv_out_seq
  import cnv_out_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int OSR_W     = 4,
  parameter int CONV_BASE = 8,
  parameter int SLEEP_CYC = 3,
  parameter int HALF_CYC  = 2,
  parameter int ABORT_MIN = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic [OSR_W-1:0] osr_i,
  input  logic [WORD_W-1:0] result_i,
  output logic             sck_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             busy_o
);
  localparam int IW      = $clog2(WORD_W);
  localparam int PH_W    = IW + 1;
  localparam int MAX_LEN = CONV_BASE * (2 ** OSR_W);
  localparam int TW      = $clog2((MAX_LEN > SLEEP_CYC) ? MAX_LEN : SLEEP_CYC) + 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * WORD_W - 1);

  seq_state_e        state_q, state_d;
  logic              cs_q;
  logic [WORD_W-1:0] word_q;
  logic              cap;
  logic              tmr_load, tmr_done;
  logic [TW-1:0]     tmr_val, len_m1;
  logic              clk_clr, half_end;
  logic [PH_W-1:0]   ph;
  logic [PH_W:0]     rises;
  logic              abort, last;
  logic [IW-1:0]     bit_sel;

  assign rises   = ({1'b0, ph} + (PH_W+1)'(1)) >> 1;
  assign abort   = (state_q == ST_DATA) && cs_ni && !cs_q && (rises != '0);
  assign last    = (state_q == ST_DATA) && half_end && (ph == PH_LAST);
  assign bit_sel = IW'(WORD_W - 1) - ph[PH_W-1:1];

  cnv_out_timer #(.TW(TW), .RST_VAL(CONV_BASE - 1)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
  );

  cnv_out_sckgen #(.HALF_CYC(HALF_CYC), .PH_W(PH_W)) u_sck (
    .clk_i, .rst_ni, .clr_i(clk_clr), .en_i(state_q == ST_DATA),
    .ph_o(ph), .half_end_o(half_end)
  );

  cnv_out_osr #(.OSR_W(OSR_W), .PH_W(PH_W), .TW(TW), .CONV_BASE(CONV_BASE),
                .ABORT_MIN(ABORT_MIN)) u_osr (
    .osr_prog_i(osr_i), .rises_i(rises), .abort_i(abort), .len_m1_o(len_m1)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = len_m1;
    clk_clr  = 1'b0;
    cap      = 1'b0;
    unique case (state_q)
      ST_CONV: if (tmr_done) begin
        state_d  = ST_SLEEP;
        tmr_load = 1'b1;
        tmr_val  = TW'(SLEEP_CYC - 1);
        cap      = 1'b1;
      end
      ST_SLEEP: if (tmr_done) begin
        state_d = ST_DATA;
        clk_clr = 1'b1;
      end
      ST_DATA: if (abort || last) begin
        state_d  = ST_CONV;
        tmr_load = 1'b1;
      end
      default: state_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CONV;
      cs_q    <= 1'b1;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_ni;
      if (cap) word_q <= result_i;
    end
  end

  always_comb begin
    sck_o    = 1'b1;
    sdo_o    = 1'b1;
    busy_o   = 1'b1;
    sdo_oe_o = 1'b1;
    case (state_q)
      ST_SLEEP: begin
        sck_o  = 1'b0;
        sdo_o  = 1'b0;
        busy_o = 1'b0;
      end
      ST_DATA: begin
        sck_o    = ph[0];
        sdo_o    = word_q[bit_sel];
        busy_o   = 1'b0;
        sdo_oe_o = !cs_ni;
      end
      default: ;
    endcase
  end

  // R2
  sleep_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !sck_o && !sdo_o);
  // R4
  end_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> busy_o && sck_o && sdo_o);
  // R5
  abort_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> busy_o && sck_o);
  // R8
  conv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) && !tmr_done |=> busy_o);
endmodule

// File: tb/cnv_out_seq_test.sv
module cnv_out_seq_test;
  localparam int PERIOD = 10;
  localparam int BASE   = 8;
  localparam int SLP    = 3;
  localparam int HALF   = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n;
  logic [3:0]  osr;
  logic [31:0] result;
  logic        sck, sdo, sdo_oe, busy;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  string cur_tag = "R1";

  // reference model state
  int m_mode, m_left, m_hp, m_hc;
  bit m_csp;
  logic [31:0] m_word;

  always #(PERIOD/2) clk = ~clk;

  cnv_out_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .osr_i(osr), .result_i(result),
    .sck_o(sck), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .busy_o(busy)
  );

  task automatic cmp(input logic act, input logic exp, input string req, input string sig);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (scenario %s) %s act=%0b exp=%0b t=%0t", req, cur_tag, sig, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = BASE; m_hp = 0; m_hc = 0; m_csp = 1; m_word = '0;
    end else begin
      case (m_mode)
        0: if (m_left == 1) begin m_mode = 1; m_left = SLP; m_word = result; end
           else m_left--;
        1: if (m_left == 1) begin m_mode = 2; m_hp = 0; m_hc = 0; end
           else m_left--;
        default: begin
          int rises;
          rises = (m_hp + 1) / 2;
          if (cs_n && !m_csp && rises >= 1) begin
            m_mode = 0;
            m_left = BASE * (((rises >= 5) ? int'(osr) : rises) + 1);
          end else begin
            m_hc++;
            if (m_hc == HALF) begin
              m_hc = 0;
              m_hp++;
              if (m_hp == 64) begin m_mode = 0; m_left = BASE * (int'(osr) + 1); end
            end
          end
        end
      endcase
      m_csp = cs_n;
    end
    #1;
    if (rst_n) begin
      vectors++;
      case (m_mode)
        0: begin
          cmp(busy, 1'b1, "R1", "busy"); cmp(sck, 1'b1, "R1", "sck");
          cmp(sdo, 1'b1, "R1", "sdo");   cmp(sdo_oe, 1'b1, "R9", "oe");
        end
        1: begin
          cmp(busy, 1'b0, "R2", "busy"); cmp(sck, 1'b0, "R2", "sck");
          cmp(sdo, 1'b0, "R2", "sdo");   cmp(sdo_oe, 1'b1, "R9", "oe");
        end
        default: begin
          cmp(busy, 1'b0, "R3", "busy");
          cmp(sck, 1'(m_hp % 2), "R3", "sck");
          cmp(sdo, m_word[31 - m_hp/2], "R3", "sdo");
          cmp(sdo_oe, !cs_n, "R9", "oe");
        end
      endcase
    end
  end

  task automatic wait_mode(input int m);
    do @(negedge clk); while (m_mode != m);
  endtask

  task automatic abort_at(input int hp);
    do @(negedge clk); while (!(m_mode == 2 && m_hp == hp));
    cs_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b0; osr = 4'd2; result = 32'hA5C3_0F96;
    #(PERIOD*2 + 2);
    // R1: reset state
    vectors++;
    cmp(busy, 1'b1, "R1", "rst busy"); cmp(sck, 1'b1, "R1", "rst sck");
    cmp(sdo, 1'b1, "R1", "rst sdo");   cmp(sdo_oe, 1'b1, "R9", "rst oe");
    @(negedge clk) rst_n = 1'b1;

    cur_tag = "R3"; wait_mode(2); wait_mode(0);
    cur_tag = "R4"; result = 32'h1234_5678; wait_mode(2); wait_mode(0);
    // R6: abort after 2 rising edges -> k=2 despite osr 6
    cur_tag = "R6"; osr = 4'd6; result = 32'hFFFF_0001; abort_at(3);
    // R7: next normal cycle returns to osr
    cur_tag = "R7"; wait_mode(2); wait_mode(0);
    // R6 boundary: 4 edges (hp 8) -> k=4; 5 edges (hp 9) -> osr
    cur_tag = "R6"; abort_at(8);
    abort_at(9);
    // R5: abort after 7 edges
    cur_tag = "R5"; osr = 4'd15; result = 32'h8000_0000; abort_at(13);
    cur_tag = "R7"; osr = 4'd0; wait_mode(2); wait_mode(0);
    // R8: rises during conversion, sleep and before first edge ignored
    cur_tag = "R8"; cs_n = 1'b1; @(negedge clk) cs_n = 1'b0;
    wait_mode(1); cs_n = 1'b1; @(negedge clk) cs_n = 1'b0;
    wait_mode(2); cs_n = 1'b1;
    // R9: select high through the whole data phase
    cur_tag = "R9"; wait_mode(0); cs_n = 1'b0;
    result = 32'h0000_0001; osr = 4'd1; wait_mode(2); wait_mode(0);
    repeat (5) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 40000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (scenario %s) act=running exp=finished", cur_tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule